// File: doc/BRIEF.md
# Sequential Nonrestoring Unsigned Divider

This block divides one unsigned integer by another of the same width and returns both the quotient and the remainder. It works over several clock cycles and produces one quotient bit per cycle. It keeps three registers: a partial remainder that is one bit wider than the operands and held in two's complement, a shift register that starts with the dividend and ends with the quotient, and a register that holds the divisor. One adder/subtractor serves every step. The sign of the partial remainder decides whether the divisor is added or subtracted on the next step, so no step ever has to restore an earlier value.

A caller pulses `start` while the block is idle, with both operands on the inputs. `busy` then stays high for the width-many iterations and one final correction cycle. That cycle adds the divisor back once if the remainder came out negative. After it, `done` pulses for a single cycle and the results stay on the outputs until the next accepted start. A zero divisor raises a flag. In that case the numeric results carry no meaning, but the handshake still completes on the normal schedule.

Top module: `nrdiv_top`

## Requirements
- R1: During reset and in the first cycle after reset, `busy`, `done`, `div_by_zero`, `quotient` and `remainder` are all zero.
- R2: A `start` sampled high while idle captures `dividend` and `divisor`. `busy` is then high for exactly W+1 consecutive cycles, beginning the cycle after that edge.
- R3: `done` is high for exactly one cycle. That cycle is the one that follows the last `busy` cycle, and `busy` is low during it.
- R4: For a nonzero divisor, `quotient` equals the integer part of dividend / divisor (unsigned, W bits) while `done` is high.
- R5: For a nonzero divisor, `remainder` equals dividend modulo divisor while `done` is high. It is always non-negative and smaller than the divisor, even when the last iteration left the partial remainder negative.
- R6: A `start` pulse seen while `busy` is high has no effect. The operands it carries are ignored, and both the result and the cycle of `done` are those of the division already running.
- R7: `div_by_zero` is 1 while `done` is high if the captured divisor was zero, and 0 otherwise. A division by zero still ends with a `done` pulse on the normal schedule.
- R8: Once idle, `quotient`, `remainder` and `div_by_zero` hold their values until the next accepted `start`.
- R9: The boundary operand cases give the correct results: a dividend smaller than the divisor gives quotient 0 and remainder equal to the dividend; all-ones divided by 1 gives all-ones with remainder 0; a dividend equal to the divisor gives 1 with remainder 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a division when idle |
| dividend | input | W | Unsigned dividend, sampled with start |
| divisor | input | W | Unsigned divisor, sampled with start |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse when results are final |
| quotient | output | W | Unsigned quotient |
| remainder | output | W | Unsigned remainder |
| div_by_zero | output | 1 | Captured divisor was zero |

## Verification
`busy` is due one edge after the start edge. `done` and the final quotient, remainder and flag are due W+2 edges after it, and `done` falls one edge after that. Every task drives inputs on the falling edge and reads outputs on the falling edge. It checks `busy` on each of the W+1 falling edges that follow the start, then checks `done` and the results on the next falling edge, and checks that `done` has fallen on the one after. The test of an ignored start injects the second pulse in the middle of this window and keeps the same schedule. The hold test waits idle cycles before it reads the outputs again.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;

    typedef enum logic [1:0] {
        DV_IDLE = 2'd0,
        DV_ITER = 2'd1,
        DV_FIX  = 2'd2
    } dv_state_t;

    typedef struct packed {
        logic load;
        logic iter;
        logic fix;
    } dv_ctl_t;

    // quotient bit retired after an add/subtract: 1 when the result is non-negative
    function automatic logic qbit_from_sign(input logic sign_bit);
        return ~sign_bit;
    endfunction

    // choose subtract while the partial remainder is non-negative
    function automatic logic pick_subtract(input logic sign_bit);
        return ~sign_bit;
    endfunction

endpackage

// File: rtl/nrdiv_ctrl.sv
module nrdiv_ctrl
    import nrdiv_pkg::*;
#(
    parameter int W = 8
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    output dv_ctl_t ctl,
    output logic    busy,
    output logic    done
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    dv_state_t     state_q;
    logic [CW-1:0] cnt_q;
    logic          done_q;

    always_comb begin
        ctl.load = (state_q == DV_IDLE) && start;
        ctl.iter = (state_q == DV_ITER);
        ctl.fix  = (state_q == DV_FIX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DV_IDLE;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                DV_IDLE: begin
                    if (start) begin
                        state_q <= DV_ITER;
                        cnt_q   <= '0;
                    end
                end
                DV_ITER: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST) state_q <= DV_FIX;
                end
                DV_FIX: begin
                    state_q <= DV_IDLE;
                    done_q  <= 1'b1;
                end
                default: state_q <= DV_IDLE;
            endcase
        end
    end

    assign busy = (state_q != DV_IDLE);
    assign done = done_q;

    AST_ITER_COUNT: assert property (@(posedge clk) disable iff (rst)
        (state_q == DV_ITER) |-> (cnt_q < CW'(W))); // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R3
    AST_DONE_AFTER_FIX: assert property (@(posedge clk) disable iff (rst)
        (state_q == DV_FIX) |=> (done && !busy)); // R3
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(busy && done)); // R3

endmodule

// File: rtl/nrdiv_shifter.sv
module nrdiv_shifter #(
    parameter int W = 8
) (
    input  logic [W:0]   p_in,
    input  logic [W-1:0] a_in,
    output logic [W:0]   p_sh,
    output logic [W-1:0] a_sh
);
    // the pair (P,A) moves left as one value; the top bit of A enters P
    assign p_sh = {p_in[W-1:0], a_in[W-1]};
    assign a_sh = {a_in[W-2:0], 1'b0};
endmodule

// File: rtl/nrdiv_addsub.sv
module nrdiv_addsub #(
    parameter int W = 8
) (
    input  logic [W:0]   x,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W:0]   y
);
    logic [W:0] b_ext;
    logic [W:0] b_opnd;

    assign b_ext  = {1'b0, b};
    assign b_opnd = sub ? ~b_ext : b_ext;
    assign y      = x + b_opnd + {{W{1'b0}}, sub};
endmodule

// File: rtl/nrdiv_top.sv
module nrdiv_top
    import nrdiv_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder,
    output logic         div_by_zero
);
    dv_ctl_t      ctl;
    logic [W:0]   p_q;
    logic [W-1:0] a_q;
    logic [W-1:0] b_q;
    logic         dbz_q;

    logic [W:0]   p_sh;
    logic [W-1:0] a_sh;
    logic [W:0]   alu_x;
    logic         alu_sub;
    logic [W:0]   alu_y;

    nrdiv_ctrl #(.W(W)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .ctl   (ctl),
        .busy  (busy),
        .done  (done)
    );

    nrdiv_shifter #(.W(W)) u_shift (
        .p_in (p_q),
        .a_in (a_q),
        .p_sh (p_sh),
        .a_sh (a_sh)
    );

    // the one adder: an iteration adds or subtracts on the shifted P, the fix cycle adds B to P
    always_comb begin
        if (ctl.fix) begin
            alu_x   = p_q;
            alu_sub = 1'b0;
        end else begin
            alu_x   = p_sh;
            alu_sub = pick_subtract(p_q[W]);
        end
    end

    nrdiv_addsub #(.W(W)) u_alu (
        .x   (alu_x),
        .b   (b_q),
        .sub (alu_sub),
        .y   (alu_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            p_q   <= '0;
            a_q   <= '0;
            b_q   <= '0;
            dbz_q <= 1'b0;
        end else if (ctl.load) begin
            p_q   <= '0;
            a_q   <= dividend;
            b_q   <= divisor;
            dbz_q <= (divisor == '0);
        end else if (ctl.iter) begin
            p_q <= alu_y;
            a_q <= {a_sh[W-1:1], qbit_from_sign(alu_y[W])};
        end else if (ctl.fix) begin
            if (p_q[W]) p_q <= alu_y;
        end
    end

    assign quotient    = a_q;
    assign remainder   = p_q[W-1:0];
    assign div_by_zero = dbz_q;

    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (rst)
        (done && !div_by_zero) |-> (remainder < b_q)); // R5
    AST_FIX_NONNEG: assert property (@(posedge clk) disable iff (rst)
        ctl.fix |=> !p_q[W]); // R5
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(b_q)); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(quotient) && $stable(remainder) && $stable(div_by_zero))); // R8

endmodule

// File: tb/test_nrdiv_top.sv
module test_nrdiv_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic [W-1:0] dividend;
    logic [W-1:0] divisor;
    logic         busy;
    logic         done;
    logic [W-1:0] quotient;
    logic [W-1:0] remainder;
    logic         div_by_zero;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10ns clk = ~clk;

    nrdiv_top #(.W(W)) i_nrdiv_top (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .dividend    (dividend),
        .divisor     (divisor),
        .busy        (busy),
        .done        (done),
        .quotient    (quotient),
        .remainder   (remainder),
        .div_by_zero (div_by_zero)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one division; when inject is set a second start with other operands arrives mid-run
    task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b, input bit inject);
        logic [W-1:0] eq;
        logic [W-1:0] er;
        eq = (b != 0) ? a / b : '0;
        er = (b != 0) ? a % b : '0;
        @(negedge clk);
        dividend = a; divisor = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 busy after start", 32'(busy), 32'd1);
        for (int k = 0; k < W; k++) begin
            if (inject && k == 3) begin
                dividend = ~a; divisor = 8'd3; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            chk("R2 busy held", 32'(busy), 32'd1);
            chk("R3 no early done", 32'(done), 32'd0);
        end
        start = 1'b0;
        @(negedge clk);
        chk("R3 done due", 32'(done), 32'd1);
        chk("R3 busy low at done", 32'(busy), 32'd0);
        chk("R7 flag", 32'(div_by_zero), 32'(b == 0));
        if (b != 0) begin
            chk(inject ? "R6 quotient unaffected" : "R4 quotient", 32'(quotient), 32'(eq));
            chk(inject ? "R6 remainder unaffected" : "R5 remainder", 32'(remainder), 32'(er));
        end
        @(negedge clk);
        chk("R3 done falls", 32'(done), 32'd0);
    endtask

    task automatic test_reset;
        rst = 1'b1; start = 1'b0; dividend = '0; divisor = '0;
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", 32'(busy), 32'd0);
        chk("R1 done in reset", 32'(done), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 flag", 32'(div_by_zero), 32'd0);
        chk("R1 quotient", 32'(quotient), 32'd0);
        chk("R1 remainder", 32'(remainder), 32'd0);
    endtask

    task automatic test_basic;
        run_div(8'd14, 8'd3, 1'b0);   // R4 R5
        run_div(8'd200, 8'd7, 1'b0);
        run_div(8'd7, 8'd2, 1'b0);
        run_div(8'd149, 8'd5, 1'b0);
        run_div(8'd255, 8'd254, 1'b0);
        run_div(8'd128, 8'd255, 1'b0);
    endtask

    task automatic test_bounds;
        run_div(8'd5, 8'd9, 1'b0);    // R9 smaller dividend
        chk("R9 q small", 32'(quotient), 32'd0);
        chk("R9 r small", 32'(remainder), 32'd5);
        run_div(8'd255, 8'd1, 1'b0);  // R9 all ones by one
        chk("R9 q ones", 32'(quotient), 32'd255);
        chk("R9 r ones", 32'(remainder), 32'd0);
        run_div(8'd77, 8'd77, 1'b0);  // R9 equal
        chk("R9 q equal", 32'(quotient), 32'd1);
        run_div(8'd0, 8'd13, 1'b0);
        chk("R9 q zero dividend", 32'(quotient), 32'd0);
    endtask

    task automatic test_sweep;
        for (int i = 0; i < 40; i++) begin
            run_div(8'((i * 37 + 11) % 256), 8'((i * 13) % 255 + 1), 1'b0);
        end
    endtask

    task automatic test_ignore;
        run_div(8'd250, 8'd11, 1'b1); // R6
        chk("R6 flag stays clear", 32'(div_by_zero), 32'd0);
    endtask

    task automatic test_zero;
        run_div(8'd99, 8'd0, 1'b0);   // R7
        chk("R7 flag set", 32'(div_by_zero), 32'd1);
        run_div(8'd99, 8'd4, 1'b0);
        chk("R7 flag cleared", 32'(div_by_zero), 32'd0);
    endtask

    task automatic test_hold;
        run_div(8'd123, 8'd10, 1'b0);
        dividend = 8'd1; divisor = 8'd0;
        repeat (5) @(negedge clk);
        chk("R8 quotient held", 32'(quotient), 32'd12);
        chk("R8 remainder held", 32'(remainder), 32'd3);
        chk("R8 flag held", 32'(div_by_zero), 32'd0);
        chk("R8 stays idle", 32'(busy), 32'd0);
    endtask

    initial begin
        test_reset;
        test_basic;
        test_bounds;
        test_ignore;
        test_zero;
        test_hold;
        test_sweep;
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(20ns * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule